// File: doc/BRIEF.md
# Write command frame parser

This block sits behind the gap decoder of a contactless memory device and turns one received write frame into one decision. For each bit it receives the bit value with a valid strobe and the running bit count, and when the field has been quiet long enough it receives an end-of-frame pulse together with the decoder's gap-fail flag. The first two bits of the frame are the command code. A write command carries a lock bit, a data word and a block address. It can also carry a password, which is checked serially against the stored password word as the bits arrive.

One clock after the end-of-frame pulse the block raises exactly one result strobe. The result is a program request with its lock, data and address fields, a stop request, a modulation enable for the answer-on-request case, or a restart of read mode at block 1. A stop request puts the block into a silenced state. In that state further frames get no answer. Only the power-on reset leaves the silenced state. The ordinary block reset does not clear it.

Bits arrive most significant first. The first data bit lands in `prog_data[DATA_W-1]`, the first address bit in `prog_addr[ADDR_W-1]`, and the first password bit is compared with `pwd_word[PWD_W-1]`.

Top module: `cmd_frame_parser`

## Requirements
- R1: After power-on reset all four result strobes are low, `silenced` is low and the program fields are zero.
- R2: When not silenced, exactly one of `prog_req`, `stop_req`, `mod_en`, `read_restart` is high for one cycle, in the cycle after the one where `frame_end` is sampled. No strobe is high at any other time.
- R3: A frame with fewer than 2 bits, or whose first two bits are 00 or 01, gives `read_restart`.
- R4: If `gap_fail` is high with `frame_end`, the result is `read_restart`, whatever the frame holds.
- R5: With `pwd_on` low, a 38-bit frame starting 10 gives `prog_req`. Bit 3 is the lock, bits 4 to 35 are the data (first bit into the MSB), and bits 36 to 38 are the address (first bit into the MSB).
- R6: With `pwd_on` high, a 70-bit frame starting 10 whose bits 3 to 34 equal `pwd_word` (bit 3 against bit 31) gives `prog_req` with lock, data and address taken from bits 35 to 70. A single differing password bit gives `read_restart` instead.
- R7: With `pwd_on` low, a 70-bit frame starting 10 gives `prog_req` whatever bits 3 to 34 hold, with the fields taken from bits 35 to 70.
- R8: With `pwd_on` and `aor_on` high, a 34-bit frame starting 10 with a matching password gives `mod_en`. With `aor_on` low, or with a password mismatch, the same frame gives `read_restart`.
- R9: A frame of exactly the two bits 11 gives `stop_req` and sets `silenced`. A frame starting 11 with any further bit gives `read_restart` and leaves `silenced` low.
- R10: While `silenced` is high no strobe follows `frame_end`. Pulsing `rst_n` leaves `silenced` high. Only `por_n` clears it.
- R11: The password mismatch flag holds for the rest of a frame and is cleared when bit 1 of the next frame arrives. A failed frame followed by a correct one programs.
- R12: A frame starting 10 of any other length (such as 37 or 39, or 38 with `pwd_on` high) gives `read_restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including the silenced state |
| rst_n | input | 1 | Block reset, active low, leaves the silenced state alone |
| bit_vld | input | 1 | One received bit is present this cycle |
| bit_val | input | 1 | Value of the received bit |
| bit_cnt | input | CNT_W | Bits received in this frame, counting the current one; total at `frame_end` |
| frame_end | input | 1 | End-of-frame pulse from the decoder |
| gap_fail | input | 1 | Decoder saw an invalid gap interval in this frame; valid with `frame_end` |
| pwd_on | input | 1 | Password mode configuration |
| aor_on | input | 1 | Answer-on-request mode configuration |
| pwd_word | input | PWD_W | Stored password word |
| prog_req | output | 1 | Program request strobe |
| prog_lock | output | 1 | Lock bit of the last program request |
| prog_data | output | DATA_W | Data word of the last program request |
| prog_addr | output | ADDR_W | Block address of the last program request |
| stop_req | output | 1 | Stop request strobe |
| mod_en | output | 1 | Modulation enable strobe |
| read_restart | output | 1 | Restart read mode at block 1 strobe |
| silenced | output | 1 | Sticky stop state |

## Verification
Every result is due exactly one clock after the rising edge that samples `frame_end`. The password mismatch flag updates one clock after the offending bit. The bench changes inputs on falling edges and reads the strobes and fields on the falling edge right after the `frame_end` edge. It reads them again one cycle later to confirm the strobe has dropped, which catches a strobe that comes late, comes early or lasts too long. The silenced state is read at the same point, and again after each reset pulse, before the next frame starts.

// File: rtl/cfp_pkg.sv
`timescale 1ns/1ps
package cfp_pkg;
  localparam int OP_W = 2;
  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_STOP  = 2'b11;

  typedef enum logic [1:0] {RES_READ, RES_PROG, RES_STOP, RES_MOD} res_e;

  // lock + data + address
  function automatic int payload_len(int data_w, int addr_w);
    return 1 + data_w + addr_w;
  endfunction

  function automatic int std_len(int data_w, int addr_w);
    return OP_W + payload_len(data_w, addr_w);
  endfunction

  function automatic int pwd_len(int data_w, int addr_w, int pwd_w);
    return std_len(data_w, addr_w) + pwd_w;
  endfunction

  function automatic int aor_len(int pwd_w);
    return OP_W + pwd_w;
  endfunction

  // bit count (1-based) lies in the password window
  function automatic bit in_pwd_field(int cnt, int pwd_w);
    return (cnt > OP_W) && (cnt <= OP_W + pwd_w);
  endfunction

  // index into the stored word for bit count cnt, first bit vs MSB
  function automatic int pwd_bit_idx(int cnt, int pwd_w);
    return pwd_w + OP_W - cnt;
  endfunction

  function automatic res_e classify(logic [1:0] op, int len, logic gap,
                                    logic pwd_on, logic aor_on, logic mism,
                                    int slen, int plen, int alen);
    res_e r;
    r = RES_READ;
    if (gap || len < OP_W) r = RES_READ;
    else if (op == OP_STOP) r = (len == OP_W) ? RES_STOP : RES_READ;
    else if (op == OP_WRITE) begin
      if (pwd_on) begin
        if (mism)                     r = RES_READ;
        else if (len == plen)         r = RES_PROG;
        else if (len == alen && aor_on) r = RES_MOD;
        else                          r = RES_READ;
      end else begin
        r = (len == slen || len == plen) ? RES_PROG : RES_READ;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/cfp_field_capture.sv
`timescale 1ns/1ps
module cfp_field_capture import cfp_pkg::*; #(
  parameter int CNT_W = 7,
  parameter int PAY_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic [CNT_W-1:0] bit_cnt,
  output logic [1:0]       opcode,
  output logic [PAY_W-1:0] payload,
  output logic             frame_start
);
  logic second_bit;
  logic body_bit;

  assign frame_start = bit_vld && (bit_cnt == CNT_W'(1));
  assign second_bit  = bit_vld && (bit_cnt == CNT_W'(2));
  assign body_bit    = bit_vld && (int'(bit_cnt) > OP_W);

  // payload keeps the last PAY_W bits: lock, data, address at the frame end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode  <= '0;
      payload <= '0;
    end else if (frame_start) begin
      opcode  <= {bit_val, 1'b0};
      payload <= '0;
    end else if (second_bit) begin
      opcode[0] <= bit_val;
    end else if (body_bit) begin
      payload <= {payload[PAY_W-2:0], bit_val};
    end
  end

  assert_op_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> opcode[1] == $past(bit_val));
  assert_op_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    second_bit |=> opcode[0] == $past(bit_val));
  assert_body_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    body_bit |=> payload[0] == $past(bit_val));
endmodule

// File: rtl/cfp_pwd_check.sv
`timescale 1ns/1ps
module cfp_pwd_check import cfp_pkg::*; #(
  parameter int PWD_W = 32,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             frame_start,
  input  logic             pwd_on,
  input  logic [PWD_W-1:0] pwd_word,
  output logic             cmp_fail,
  output logic             mismatch
);
  localparam int IW = (PWD_W > 1) ? $clog2(PWD_W) : 1;

  logic          in_field;
  logic [IW-1:0] idx;
  logic          exp_bit;

  always_comb begin
    in_field = in_pwd_field(int'(bit_cnt), PWD_W);
    idx      = in_field ? IW'(pwd_bit_idx(int'(bit_cnt), PWD_W)) : '0;
    exp_bit  = pwd_word[idx];
  end

  assign cmp_fail = bit_vld && pwd_on && in_field && (bit_val != exp_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mismatch <= 1'b0;
    else if (frame_start) mismatch <= 1'b0;
    else if (cmp_fail)    mismatch <= 1'b1;
  end

  assert_fail_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fail |=> mismatch);
  assert_mism_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch && !frame_start |=> mismatch);
  assert_mism_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !mismatch);
endmodule

// File: rtl/cfp_decide.sv
`timescale 1ns/1ps
module cfp_decide import cfp_pkg::*; #(
  parameter int CNT_W  = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int PWD_W  = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              gap_fail,
  input  logic              pwd_on,
  input  logic              aor_on,
  input  logic [1:0]        opcode,
  input  logic              mismatch,
  input  logic [payload_len(DATA_W, ADDR_W)-1:0] payload,
  output logic              prog_req,
  output logic              prog_lock,
  output logic [DATA_W-1:0] prog_data,
  output logic [ADDR_W-1:0] prog_addr,
  output logic              stop_req,
  output logic              mod_en,
  output logic              read_restart,
  output logic              silenced
);
  localparam int PAY_W = payload_len(DATA_W, ADDR_W);
  localparam int SLEN  = std_len(DATA_W, ADDR_W);
  localparam int PLEN  = pwd_len(DATA_W, ADDR_W, PWD_W);
  localparam int ALEN  = aor_len(PWD_W);

  res_e verdict;
  logic take;

  always_comb verdict = classify(opcode, int'(bit_cnt), gap_fail, pwd_on,
                                 aor_on, mismatch, SLEN, PLEN, ALEN);
  assign take = frame_end && !silenced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_req     <= 1'b0;
      stop_req     <= 1'b0;
      mod_en       <= 1'b0;
      read_restart <= 1'b0;
      prog_lock    <= 1'b0;
      prog_data    <= '0;
      prog_addr    <= '0;
    end else begin
      prog_req     <= take && (verdict == RES_PROG);
      stop_req     <= take && (verdict == RES_STOP);
      mod_en       <= take && (verdict == RES_MOD);
      read_restart <= take && (verdict == RES_READ);
      if (take && verdict == RES_PROG) begin
        prog_lock <= payload[PAY_W-1];
        prog_data <= payload[PAY_W-2 -: DATA_W];
        prog_addr <= payload[ADDR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          silenced <= 1'b0;
    else if (take && verdict == RES_STOP) silenced <= 1'b1;
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, stop_req, mod_en, read_restart}));
  assert_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !silenced |=> $countones({prog_req, stop_req, mod_en, read_restart}) == 1);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !(prog_req || stop_req || mod_en || read_restart));
  assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && gap_fail && !silenced |=> read_restart);
  assert_pwd_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && pwd_on && mismatch |=> !prog_req && !mod_en);
  assert_stop_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> silenced);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
    silenced |=> silenced);
  assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && silenced |=> !(prog_req || stop_req || mod_en || read_restart));
endmodule

// File: rtl/cmd_frame_parser.sv
`timescale 1ns/1ps
module cmd_frame_parser import cfp_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int PWD_W  = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              frame_end,
  input  logic              gap_fail,
  input  logic              pwd_on,
  input  logic              aor_on,
  input  logic [PWD_W-1:0]  pwd_word,
  output logic              prog_req,
  output logic              prog_lock,
  output logic [DATA_W-1:0] prog_data,
  output logic [ADDR_W-1:0] prog_addr,
  output logic              stop_req,
  output logic              mod_en,
  output logic              read_restart,
  output logic              silenced
);
  localparam int PAY_W = payload_len(DATA_W, ADDR_W);

  // block state is reset by either source; silenced only by por_n
  logic             blk_rst_n;
  logic             frame_start;
  logic             cmp_fail;
  logic             mismatch;
  logic [1:0]       opcode;
  logic [PAY_W-1:0] payload;

  assign blk_rst_n = rst_n & por_n;

  cfp_field_capture #(.CNT_W(CNT_W), .PAY_W(PAY_W)) u_cap (
    .clk(clk), .rst_n(blk_rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .bit_cnt(bit_cnt), .opcode(opcode), .payload(payload),
    .frame_start(frame_start)
  );

  cfp_pwd_check #(.PWD_W(PWD_W), .CNT_W(CNT_W)) u_pwd (
    .clk(clk), .rst_n(blk_rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .bit_cnt(bit_cnt), .frame_start(frame_start), .pwd_on(pwd_on),
    .pwd_word(pwd_word), .cmp_fail(cmp_fail), .mismatch(mismatch)
  );

  cfp_decide #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PWD_W(PWD_W)) u_dec (
    .clk(clk), .por_n(por_n), .rst_n(blk_rst_n), .frame_end(frame_end),
    .bit_cnt(bit_cnt), .gap_fail(gap_fail), .pwd_on(pwd_on), .aor_on(aor_on),
    .opcode(opcode), .mismatch(mismatch), .payload(payload),
    .prog_req(prog_req), .prog_lock(prog_lock), .prog_data(prog_data),
    .prog_addr(prog_addr), .stop_req(stop_req), .mod_en(mod_en),
    .read_restart(read_restart), .silenced(silenced)
  );

  assert_por_clear_R1: assert property (@(posedge clk)
    !por_n |=> !silenced && !prog_req && !stop_req && !mod_en && !read_restart);
endmodule

// File: tb/sim_cmd_frame_parser.sv
`timescale 1ns/1ps
module sim_cmd_frame_parser;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        bit_vld = 1'b0, bit_val = 1'b0;
  logic [6:0]  bit_cnt = '0;
  logic        frame_end = 1'b0, gap_fail = 1'b0;
  logic        pwd_on = 1'b0, aor_on = 1'b0;
  logic [31:0] pwd_word = 32'h0;
  logic        prog_req, prog_lock, stop_req, mod_en, read_restart, silenced;
  logic [31:0] prog_data;
  logic [2:0]  prog_addr;

  cmd_frame_parser u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .bit_cnt(bit_cnt), .frame_end(frame_end), .gap_fail(gap_fail), .pwd_on(pwd_on),
    .aor_on(aor_on), .pwd_word(pwd_word), .prog_req(prog_req), .prog_lock(prog_lock),
    .prog_data(prog_data), .prog_addr(prog_addr), .stop_req(stop_req), .mod_en(mod_en),
    .read_restart(read_restart), .silenced(silenced)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic fb [0:79];
  int flen;
  logic gf;
  // model state
  bit m_stop = 0;
  int exp_res;            // 0 none, 1 read, 2 prog, 3 stop, 4 mod
  logic        e_lock;
  logic [31:0] e_data;
  logic [2:0]  e_addr;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_vec(int start, logic [63:0] v, int n);
    for (int k = 0; k < n; k++) fb[start + k] = v[n - 1 - k];
  endtask

  task automatic predict();
    int base;
    bit ok;
    base = -1;
    if (m_stop) exp_res = 0;
    else if (gf || flen < 2) exp_res = 1;
    else if (fb[0] == 1'b1 && fb[1] == 1'b1) begin
      exp_res = (flen == 2) ? 3 : 1;
      if (flen == 2) m_stop = 1;
    end else if (fb[0] == 1'b1 && fb[1] == 1'b0) begin
      if (pwd_on) begin
        ok = 1;
        for (int k = 0; k < 32; k++)
          if (2 + k < flen && fb[2 + k] !== pwd_word[31 - k]) ok = 0;
        if (!ok) exp_res = 1;
        else if (flen == 70) begin exp_res = 2; base = 34; end
        else if (flen == 34 && aor_on) exp_res = 4;
        else exp_res = 1;
      end else if (flen == 38) begin exp_res = 2; base = 2; end
      else if (flen == 70) begin exp_res = 2; base = 34; end
      else exp_res = 1;
    end else exp_res = 1;
    if (base >= 0) begin
      e_lock = fb[base];
      for (int k = 0; k < 32; k++) e_data[31 - k] = fb[base + 1 + k];
      for (int j = 0; j < 3; j++)  e_addr[2 - j] = fb[base + 33 + j];
    end
  endtask

  function automatic logic [3:0] strobes_of(int r);
    case (r)
      1: return 4'b0001;
      2: return 4'b1000;
      3: return 4'b0100;
      4: return 4'b0010;
      default: return 4'b0000;
    endcase
  endfunction

  // entered on a falling edge
  task automatic run_frame(string req);
    for (int i = 0; i < flen; i++) begin
      bit_vld = 1'b1; bit_val = fb[i]; bit_cnt = 7'(i + 1);
      @(negedge clk);
    end
    bit_vld = 1'b0; bit_val = 1'b0;
    frame_end = 1'b1; gap_fail = gf;
    @(negedge clk);
    frame_end = 1'b0; gap_fail = 1'b0;
    predict();
    chk(req, "strobes", {prog_req, stop_req, mod_en, read_restart}, strobes_of(exp_res));
    if (exp_res == 2) begin
      chk(req, "lock", prog_lock, e_lock);
      chk(req, "data", prog_data, e_data);
      chk(req, "addr", prog_addr, e_addr);
    end
    chk(req, "silenced", silenced, m_stop);
    @(negedge clk);
    chk("R2", "strobe width", {prog_req, stop_req, mod_en, read_restart}, 4'b0000);
    gf = 1'b0;
  endtask

  task automatic mk_write(int plen_bits, logic [31:0] pw);
    fb[0] = 1'b1; fb[1] = 1'b0;
    if (plen_bits > 0) put_vec(2, pw, 32);
    put_vec(2 + plen_bits, {$urandom, $urandom}, 36);
    flen = 38 + plen_bits;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd5551));
    gf = 1'b0;
    pwd_word = 32'hA5C3_0F96;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "strobes", {prog_req, stop_req, mod_en, read_restart}, 4'b0000);
    chk("R1", "silenced", silenced, 1'b0);
    chk("R1", "data", prog_data, 32'h0);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R5 standard write
    mk_write(0, 0); run_frame("R5");
    fb[0] = 1; fb[1] = 0; fb[2] = 1; put_vec(3, 32'hDEAD_BEEF, 32); put_vec(35, 3'b101, 3); flen = 38;
    run_frame("R5");
    chk("R5", "fixed data", prog_data, 32'hDEAD_BEEF);
    chk("R5", "fixed addr", prog_addr, 3'b101);
    // R3 bad opcode / short
    mk_write(0, 0); fb[0] = 0; fb[1] = 0; run_frame("R3");
    mk_write(0, 0); fb[0] = 0; fb[1] = 1; run_frame("R3");
    flen = 1; fb[0] = 1; run_frame("R3");
    flen = 0; run_frame("R3");
    // R4 gap fail
    mk_write(0, 0); gf = 1'b1; run_frame("R4");
    // R12 wrong lengths
    mk_write(0, 0); flen = 37; run_frame("R12");
    mk_write(0, 0); fb[38] = 1; flen = 39; run_frame("R12");
    // R7 pwd off, arbitrary password field
    mk_write(32, $urandom); run_frame("R7");
    // R6 password on
    pwd_on = 1'b1;
    mk_write(32, pwd_word); run_frame("R6");
    mk_write(32, pwd_word ^ 32'h8000_0000); run_frame("R6");
    mk_write(32, pwd_word ^ 32'h0000_0001); run_frame("R6");
    mk_write(0, 0); run_frame("R12");
    // R11 mismatch cleared by next frame
    mk_write(32, pwd_word ^ 32'h0001_0000); run_frame("R11");
    mk_write(32, pwd_word); run_frame("R11");
    // R8 answer-on-request
    aor_on = 1'b1;
    mk_write(32, pwd_word); flen = 34; run_frame("R8");
    mk_write(32, pwd_word ^ 32'h0000_0100); flen = 34; run_frame("R8");
    aor_on = 1'b0;
    mk_write(32, pwd_word); flen = 34; run_frame("R8");
    pwd_on = 1'b0;
    // R9 stop with extra bits
    fb[0] = 1; fb[1] = 1; fb[2] = 0; flen = 3; run_frame("R9");

    // random mix, no exact stop frame
    for (int n = 0; n < 300; n++) begin
      int kind;
      pwd_on = 1'($urandom); aor_on = 1'($urandom);
      pwd_word = $urandom;
      kind = $urandom_range(0, 5);
      case (kind)
        0: mk_write(0, 0);
        1: mk_write(32, pwd_word);
        2: mk_write(32, pwd_word ^ (32'h1 << $urandom_range(0, 31)));
        3: begin mk_write(32, ($urandom_range(0, 1) == 0) ? pwd_word : ~pwd_word); flen = 34; end
        4: begin flen = $urandom_range(0, 72); for (int i = 0; i < flen; i++) fb[i] = 1'($urandom); end
        default: begin fb[0] = 1; fb[1] = 1; flen = 2 + $urandom_range(1, 4);
                   for (int i = 2; i < flen; i++) fb[i] = 1'($urandom); end
      endcase
      if (flen == 2 && fb[0] && fb[1]) fb[1] = 1'b0;
      gf = ($urandom_range(0, 9) == 0);
      run_frame("R2");
    end

    // R9 exact stop, then R10
    pwd_on = 1'b0; aor_on = 1'b0;
    fb[0] = 1; fb[1] = 1; flen = 2; run_frame("R9");
    mk_write(0, 0); run_frame("R10");
    fb[0] = 1; fb[1] = 1; flen = 2; run_frame("R10");
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R10", "silenced after rst_n", silenced, 1'b1);
    mk_write(0, 0); run_frame("R10");
    por_n = 1'b0; @(negedge clk); por_n = 1'b1; m_stop = 0; @(negedge clk);
    chk("R10", "silenced after por_n", silenced, 1'b0);
    mk_write(0, 0); run_frame("R10");

    summary();
  end
endmodule